// File: doc/BRIEF.md
# Cascadable Serial Command Frame Port

This block is the serial front end of a 48-channel LED PWM controller. A host, or the previous device in a daisy chain, clocks a fixed 584-bit command frame into one long shift register on the rising edges of the serial clock. The frame carries 48 twelve-bit channel words, with the highest channel first, and an 8-bit command field in its last eight bits. Nothing is acted on while bits arrive. Only a rising edge on the latch input decodes the command field. The decode raises a one-cycle strobe for the matching target and presents the 576 data bits on a payload bus.

On that same latch edge the shift register is overwritten with a status frame. The status frame holds the upper nibble of the command just latched, four status flags, 48 open-LED fault bits and 48 six-bit correction values, with zeros below them. The status frame then leaves on the serial output, MSB first, while the next command frame enters. Every write therefore returns the status captured at the previous latch. The serial output is retimed on the falling clock edge. The serial clock is also forwarded so that a downstream device can sample the output with it, and a downstream device may ignore that forwarded clock.

Top module: `sfi_frame_if`

## Requirements
- R1: On each rising edge of `sck_i` where `ld_i` is low, the shift register moves one place toward its MSB and takes `sdi_i` into bit 0. Only the last 584 bits shifted in form the frame: bit 583 is the first bit sent, and extra leading bits fall out.
- R2: A rising edge of `sck_i` that sees `ld_i` high after it was low there on the previous edge is a latch event. The latch event decodes frame bits [7:0] and, on that edge, sets exactly one bit of `cmd_stb_o` for a known code: 8'h10 gives bit 0, 8'h20 gives bit 1, 8'h31 gives bit 2, 8'h4F gives bit 3. The strobe returns to zero on the next rising edge.
- R3: Any other command code produces no strobe on its latch event.
- R4: On a latch event `payload_o` takes frame bits [583:8], with channel 48 in the top twelve bits. It holds that value until the next latch event.
- R5: On a latch event the shift register is loaded, from the MSB downward, with: command bits [7:4], then `olt_i`, `syc_i`, `phs_i`, `crd_i`, then `nol_i[47:0]`, then `cor_i[287:0]` with channel 48 highest and each value MSB first, then 240 zero bits.
- R6: `sdo_o` takes the shift register MSB on every falling edge of `sck_i`. The first status bit is therefore valid after the falling edge that follows the latch edge, and `sdo_o` never changes on a rising edge.
- R7: While `ld_i` stays high after a latch event, the shift register holds its contents, `sdi_i` is ignored and no further strobe occurs.
- R8: `sck_o` equals `sck_i` at all times.
- R9: While `rst_n` is low, the shift register, `sdo_o`, `cmd_stb_o` and `payload_o` are zero, and the latch detector is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck_i | input | 1 | Serial clock; data is taken in on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial command data in |
| ld_i | input | 1 | Latch request, acted on at its first high rising clock edge |
| olt_i | input | 1 | Open-LED self-test flag for the status frame |
| syc_i | input | 1 | Sync-error flag for the status frame |
| phs_i | input | 1 | Phase-shift mode flag for the status frame |
| crd_i | input | 1 | Correction-disabled flag for the status frame |
| nol_i | input | 48 | Per-channel open-LED faults, channel 48 in the top bit |
| cor_i | input | 288 | Per-channel 6-bit correction values, channel 48 highest |
| sck_o | output | 1 | Forwarded serial clock for the next device |
| sdo_o | output | 1 | Serial status data out, changing on falling edges |
| cmd_stb_o | output | 4 | One-cycle decode strobes, one per known command |
| payload_o | output | 576 | Channel data captured at the last latch event |

## Verification
The assertions assume that `ld_i`, `sdi_i` and the status inputs change only away from the rising edge of `sck_i`. They also assume that the serial clock keeps running while a latch is in progress, so that the latch detector sees `ld_i` both high and low on rising edges. The bench keeps within these limits by driving every input one nanosecond after a falling edge. It never pulses `ld_i` for less than a full clock period, and it holds the status inputs steady from before each latch edge until that edge has passed. Reset is likewise applied and released just after a falling edge.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

  // width of the command field at the bottom of every frame
  localparam int CMD_W = 8;
  // number of command codes that raise a strobe
  localparam int NUM_CMDS = 4;
  // number of flag bits following the command nibble in the status frame
  localparam int FLAG_W = 4;
  // number of command bits echoed back in the status frame
  localparam int ECHO_W = 4;

  // strobe bit i fires for code CMD_CODES[i]
  localparam logic [CMD_W-1:0] CMD_CODES [NUM_CMDS] = '{8'h10, 8'h20, 8'h31, 8'h4F};

  // status frame width used by the fields, before zero padding
  function automatic int status_used_w(input int channels, input int cor_w);
    return ECHO_W + FLAG_W + channels + channels * cor_w;
  endfunction

endpackage

// File: rtl/sfi_shift_reg.sv
module sfi_shift_reg #(
  parameter int FW = 584
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          load_en,
  input  logic          sdi,
  input  logic [FW-1:0] load_word,
  output logic [FW-1:0] sr
);

  // parallel load wins over shifting; neither means hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load_en) begin
      sr <= load_word;
    end else if (shift_en) begin
      sr <= {sr[FW-2:0], sdi};
    end
  end

endmodule

// File: rtl/sfi_status_pack.sv
module sfi_status_pack #(
  parameter int CHANNELS = 48,
  parameter int COR_W    = 6,
  parameter int FW       = 584
) (
  input  logic [sfi_pkg::ECHO_W-1:0]   cmd_hi,
  input  logic [sfi_pkg::FLAG_W-1:0]   flags,
  input  logic [CHANNELS-1:0]          nol,
  input  logic [CHANNELS*COR_W-1:0]    cor,
  output logic [FW-1:0]                status_word
);

  localparam int USED_W = sfi_pkg::status_used_w(CHANNELS, COR_W);
  localparam int PAD_W  = FW - USED_W;

  // fields packed MSB downward, zero fill at the bottom
  function automatic logic [FW-1:0] pack_status(
    input logic [sfi_pkg::ECHO_W-1:0] c,
    input logic [sfi_pkg::FLAG_W-1:0] f,
    input logic [CHANNELS-1:0]        n,
    input logic [CHANNELS*COR_W-1:0]  k
  );
    return {c, f, n, k, {PAD_W{1'b0}}};
  endfunction

  assign status_word = pack_status(cmd_hi, flags, nol, cor);

endmodule

// File: rtl/sfi_cmd_decode.sv
module sfi_cmd_decode #(
  parameter int FW    = 584,
  parameter int PAY_W = 576
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          latch_evt,
  input  logic [FW-1:0]                 frame,
  output logic [sfi_pkg::NUM_CMDS-1:0]  cmd_stb,
  output logic [PAY_W-1:0]              payload
);

  localparam int CMD_W = sfi_pkg::CMD_W;

  logic [CMD_W-1:0]             cmd_field;
  logic [sfi_pkg::NUM_CMDS-1:0] code_hit;

  assign cmd_field = frame[CMD_W-1:0];

  // one comparator per known command code
  for (genvar g = 0; g < sfi_pkg::NUM_CMDS; g++) begin : g_code
    assign code_hit[g] = (cmd_field == sfi_pkg::CMD_CODES[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb <= '0;
      payload <= '0;
    end else begin
      cmd_stb <= latch_evt ? code_hit : '0;
      if (latch_evt) begin
        payload <= frame[FW-1:CMD_W];
      end
    end
  end

endmodule

// File: rtl/sfi_sdo_out.sv
module sfi_sdo_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_msb,
  output logic sdo,
  output logic clk_fwd
);

  // retime on the falling edge: half a period of setup for the next device
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo <= 1'b0;
    end else begin
      sdo <= sr_msb;
    end
  end

  assign clk_fwd = clk;

endmodule

// File: rtl/sfi_frame_if.sv
module sfi_frame_if #(
  parameter int CHANNELS = 48,
  parameter int DATA_W   = 12,
  parameter int COR_W    = 6
) (
  input  logic                               sck_i,
  input  logic                               rst_n,
  input  logic                               sdi_i,
  input  logic                               ld_i,
  input  logic                               olt_i,
  input  logic                               syc_i,
  input  logic                               phs_i,
  input  logic                               crd_i,
  input  logic [CHANNELS-1:0]                nol_i,
  input  logic [CHANNELS*COR_W-1:0]          cor_i,
  output logic                               sck_o,
  output logic                               sdo_o,
  output logic [sfi_pkg::NUM_CMDS-1:0]       cmd_stb_o,
  output logic [CHANNELS*DATA_W-1:0]         payload_o
);

  localparam int CMD_W  = sfi_pkg::CMD_W;
  localparam int ECHO_W = sfi_pkg::ECHO_W;
  localparam int PAY_W  = CHANNELS * DATA_W;
  localparam int FW     = PAY_W + CMD_W;

  logic          ld_q;
  logic          latch_evt;
  logic          shift_en;
  logic [FW-1:0] sr_q;
  logic [FW-1:0] status_w;

  // latch request is taken once, at the first rising edge that sees it high
  always_ff @(posedge sck_i or negedge rst_n) begin
    if (!rst_n) begin
      ld_q <= 1'b0;
    end else begin
      ld_q <= ld_i;
    end
  end

  assign latch_evt = ld_i & ~ld_q;
  assign shift_en  = ~ld_i;

  sfi_status_pack #(
    .CHANNELS (CHANNELS),
    .COR_W    (COR_W),
    .FW       (FW)
  ) u_pack (
    .cmd_hi      (sr_q[CMD_W-1 -: ECHO_W]),
    .flags       ({olt_i, syc_i, phs_i, crd_i}),
    .nol         (nol_i),
    .cor         (cor_i),
    .status_word (status_w)
  );

  sfi_shift_reg #(
    .FW (FW)
  ) u_sr (
    .clk       (sck_i),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .load_en   (latch_evt),
    .sdi       (sdi_i),
    .load_word (status_w),
    .sr        (sr_q)
  );

  sfi_cmd_decode #(
    .FW    (FW),
    .PAY_W (PAY_W)
  ) u_dec (
    .clk       (sck_i),
    .rst_n     (rst_n),
    .latch_evt (latch_evt),
    .frame     (sr_q),
    .cmd_stb   (cmd_stb_o),
    .payload   (payload_o)
  );

  sfi_sdo_out u_out (
    .clk     (sck_i),
    .rst_n   (rst_n),
    .sr_msb  (sr_q[FW-1]),
    .sdo     (sdo_o),
    .clk_fwd (sck_o)
  );

endmodule

// File: rtl/sfi_frame_if_chk.sv
module sfi_frame_if_chk #(
  parameter int FW    = 584,
  parameter int PAY_W = 576,
  parameter int NSTB  = 4
) (
  input logic             sck_i,
  input logic             rst_n,
  input logic             ld_i,
  input logic             sdi_i,
  input logic             latch_evt,
  input logic [FW-1:0]    sr,
  input logic [FW-1:0]    status_word,
  input logic             sdo_o,
  input logic [NSTB-1:0]  cmd_stb_o,
  input logic [PAY_W-1:0] payload_o
);

  p_shift_r1: assert property (@(posedge sck_i) disable iff (!rst_n)
    !ld_i |=> sr == {$past(sr[FW-2:0]), $past(sdi_i)});

  p_onehot_r2: assert property (@(posedge sck_i) disable iff (!rst_n)
    $onehot0(cmd_stb_o));

  p_pulse_r2: assert property (@(posedge sck_i) disable iff (!rst_n)
    (cmd_stb_o != '0) |=> (cmd_stb_o == '0));

  p_payload_cap_r4: assert property (@(posedge sck_i) disable iff (!rst_n)
    latch_evt |=> payload_o == $past(sr[FW-1:FW-PAY_W]));

  p_payload_keep_r4: assert property (@(posedge sck_i) disable iff (!rst_n)
    !latch_evt |=> $stable(payload_o));

  p_status_load_r5: assert property (@(posedge sck_i) disable iff (!rst_n)
    latch_evt |=> sr == $past(status_word));

  p_sdo_msb_r6: assert property (@(posedge sck_i) disable iff (!rst_n)
    sdo_o == sr[FW-1]);

  p_hold_r7: assert property (@(posedge sck_i) disable iff (!rst_n)
    (ld_i && !latch_evt) |=> $stable(sr));

  p_no_restrobe_r7: assert property (@(posedge sck_i) disable iff (!rst_n)
    (ld_i && !latch_evt) |=> (cmd_stb_o == '0));

endmodule

bind sfi_frame_if sfi_frame_if_chk #(
  .FW    (FW),
  .PAY_W (PAY_W),
  .NSTB  (sfi_pkg::NUM_CMDS)
) u_chk (
  .sck_i       (sck_i),
  .rst_n       (rst_n),
  .ld_i        (ld_i),
  .sdi_i       (sdi_i),
  .latch_evt   (latch_evt),
  .sr          (sr_q),
  .status_word (status_w),
  .sdo_o       (sdo_o),
  .cmd_stb_o   (cmd_stb_o),
  .payload_o   (payload_o)
);

// File: tb/sfi_frame_if_tb.sv
`timescale 1ns/1ps
module sfi_frame_if_tb;

  localparam int CH    = 48;
  localparam int DW    = 12;
  localparam int CW    = 6;
  localparam int PAY_W = CH * DW;
  localparam int FW    = PAY_W + 8;
  localparam int NV    = 7;
  // each entry: {command code, expected strobe vector}
  localparam logic [11:0] VEC [NV] = '{12'h101, 12'h202, 12'h314, 12'h4F8,
                                       12'h000, 12'hFF0, 12'h110};

  logic sck = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0;
  logic ld = 1'b0;
  logic olt = 1'b0, syc = 1'b0, phs = 1'b0, crd = 1'b0;
  logic [CH-1:0]    nol = '0;
  logic [CH*CW-1:0] cor = '0;
  logic             sck_o, sdo;
  logic [3:0]       stb;
  logic [PAY_W-1:0] payload;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  sdo_moved;

  always #2 sck = ~sck;

  sfi_frame_if u_dut (
    .sck_i(sck), .rst_n(rst_n), .sdi_i(sdi), .ld_i(ld),
    .olt_i(olt), .syc_i(syc), .phs_i(phs), .crd_i(crd),
    .nol_i(nol), .cor_i(cor),
    .sck_o(sck_o), .sdo_o(sdo), .cmd_stb_o(stb), .payload_o(payload)
  );

  task automatic check(input bit ok, input string req,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PAY_W-1:0] data_pat(input int k);
    logic [PAY_W-1:0] d;
    for (int ch = 0; ch < CH; ch++) d[ch*DW +: DW] = 12'((ch * 37 + k * 101 + 5) % 4096);
    return d;
  endfunction

  task automatic set_status(input int k);
    olt = k[0]; syc = k[1]; phs = k[2]; crd = ~k[0];
    for (int ch = 0; ch < CH; ch++) begin
      nol[ch] = ((ch + k) % 3 == 0);
      cor[ch*CW +: CW] = 6'((ch * 7 + k * 3) % 64);
    end
  endtask

  // expected status built bit by bit from the top, per R5
  function automatic logic [FW-1:0] exp_status(input logic [7:0] cmd);
    logic [FW-1:0] s = '0;
    int p = FW - 1;
    for (int b = 7; b >= 4; b--) begin s[p] = cmd[b]; p--; end
    s[p] = olt; p--; s[p] = syc; p--; s[p] = phs; p--; s[p] = crd; p--;
    for (int ch = CH - 1; ch >= 0; ch--) begin s[p] = nol[ch]; p--; end
    for (int ch = CH - 1; ch >= 0; ch--)
      for (int b = CW - 1; b >= 0; b--) begin s[p] = cor[ch*CW + b]; p--; end
    return s;
  endfunction

  // entered and left at negedge+1; reads sdo before each shifting edge
  task automatic send_frame(input logic [FW-1:0] f, output logic [FW-1:0] got);
    for (int i = FW - 1; i >= 0; i--) begin
      sdi = f[i];
      got[i] = sdo;
      @(posedge sck); #1;
      if (sdo !== got[i]) sdo_moved = 1'b1;
      @(negedge sck); #1;
    end
  endtask

  task automatic do_latch();
    ld = 1'b1;
    @(negedge sck); #1;
    ld = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] got, frame, exp_st;
    logic [PAY_W-1:0] d;

    repeat (3) @(negedge sck);
    #1;
    // R9 reset state
    check(sdo === 1'b0, "R9 sdo", FW'(sdo), '0);
    check(stb === 4'b0, "R9 strobe", FW'(stb), '0);
    check(payload === '0, "R9 payload", FW'(payload), '0);
    rst_n = 1'b1;

    // R8 forwarded clock at both phases
    for (int i = 0; i < 4; i++) begin
      #1 check(sck_o === sck, "R8 clock forward", FW'(sck_o), FW'(sck));
    end
    @(negedge sck); #1;

    // vector table: R1 R2 R3 R4 R5 R6
    exp_st = '0;
    sdo_moved = 1'b0;
    for (int k = 0; k < NV; k++) begin
      d = data_pat(k);
      frame = {d, VEC[k][11:4]};
      set_status(k);
      send_frame(frame, got);
      check(got === exp_st, "R5 R6 status readback", got, exp_st);
      do_latch();
      check(stb === VEC[k][3:0], (VEC[k][3:0] != 0) ? "R2 strobe" : "R3 no strobe",
            FW'(stb), FW'(VEC[k][3:0]));
      check(payload === d, "R1 R4 payload", FW'(payload), FW'(d));
      exp_st = exp_status(VEC[k][11:4]);
    end
    check(!sdo_moved, "R6 sdo stable at rising edge", FW'(sdo_moved), '0);

    // R2 strobe lasts one cycle
    @(negedge sck); #1;
    check(stb === 4'b0, "R2 strobe cleared", FW'(stb), '0);

    // R7 latch held high: one strobe, register frozen, sdi ignored
    d = data_pat(9);
    set_status(5);
    send_frame({d, 8'h20}, got);
    ld = 1'b1;
    @(negedge sck); #1;
    check(stb === 4'b0010, "R7 first strobe", FW'(stb), FW'(4'b0010));
    sdi = ~sdi;
    @(negedge sck); #1;
    check(stb === 4'b0, "R7 no second strobe", FW'(stb), '0);
    sdi = ~sdi;
    @(negedge sck); #1;
    check(stb === 4'b0, "R7 still no strobe", FW'(stb), '0);
    ld = 1'b0;
    exp_st = exp_status(8'h20);
    send_frame({data_pat(11), 8'h4F}, got);
    check(got === exp_st, "R7 status intact after hold", got, exp_st);
    do_latch();
    check(stb === 4'b1000, "R2 self test strobe", FW'(stb), FW'(4'b1000));

    // R1 extra leading bits fall out
    set_status(3);
    sdi = 1'b1;
    @(negedge sck); #1;
    d = data_pat(13);
    send_frame({d, 8'h31}, got);
    do_latch();
    check(stb === 4'b0100, "R1 extra bit strobe", FW'(stb), FW'(4'b0100));
    check(payload === d, "R1 extra bit payload", FW'(payload), FW'(d));

    // R9 mid-run reset clears outputs and register
    send_frame({data_pat(2), 8'h10}, got);
    rst_n = 1'b0;
    #1;
    check(sdo === 1'b0, "R9 sdo after reset", FW'(sdo), '0);
    check(payload === '0, "R9 payload after reset", FW'(payload), '0);
    @(negedge sck); #1;
    rst_n = 1'b1;
    send_frame({data_pat(4), 8'h00}, got);
    check(got === '0, "R9 register empty after reset", got, '0);
    do_latch();
    check(stb === 4'b0, "R3 zero code no strobe", FW'(stb), '0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule